// File: doc/BRIEF.md
# System Reset Sequencer

This block orders the reset of a whole chip. It takes reset requests from three places. The first is a shared, active-low, open-drain system reset line that other devices can pull. The second is an internal power-management event: a write asking to leave the deepest powered-down PCI state. The third is processor-side requests of core, chip or system strength, which arrive from a debug request port, from a watchdog that has expired twice, or from a software write of a 2-bit reset code. It then steps through a fixed schedule. First comes an assertion window, which for a system reset also pulls the shared line low so that its neighbours reset too. Next comes a PLL lock window, and peripheral clock groups are switched back on a few cycles before that window ends. Finally every internal reset is released in the same cycle.

The reset kinds behave differently. A core reset holds only the processor. A chip reset also holds the on-chip peripherals and the external bus reset. A system reset additionally gates the peripheral clocks and drives the shared line. A status field records the kind of the last completed reset, so software can tell a core reset from a chip reset.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A low level on `sys_rst_n_i` starts a system-kind sequence only if it is sampled on at least FILT_CYC consecutive clock edges. A shorter low pulse leaves every output unchanged. An externally started sequence never drives `sys_rst_drive_o`, and it enters its lock window two cycles after the line goes high.
- R2: An internally requested system reset asserts `sys_rst_drive_o` (the line is pulled low while it is 1) for exactly ASSERT_CYC consecutive cycles. The block never drives the line for a core or chip reset.
- R3: Every internally requested reset holds `core_rst_o` for ASSERT_CYC cycles and then for LOCK_CYC lock cycles. When the lock count ends, `core_rst_o` and `chip_rst_o` fall together, `ext_bus_rst_n_o` rises and all peripheral clock enables are 1.
- R4: During a system reset, all bits of `periph_clk_en_o` are 0 until EARLY_CYC cycles remain in the lock window, and all are 1 for those last EARLY_CYC cycles. They stay 1 throughout core and chip resets. `cpu_clk_en_o` and `pls_clk_en_o` are 1 at all times.
- R5: `chip_rst_o` is 1 and `ext_bus_rst_n_o` is 0 for the whole of a chip (2'b10) or system (2'b11) sequence. Both stay inactive during a core (2'b01) sequence.
- R6: A one-cycle pulse on `pm_d0_wr_i` starts a system-kind reset.
- R7: Reset kinds are encoded as 2'b01 core, 2'b10 chip and 2'b11 system, and 2'b00 means no request. This applies to `dbg_rst_kind_i`, to `sw_rst_kind_i` (taken when `sw_rst_wr_i` is 1) and to `wdt_rst_kind_i`. A software write of 2'b00 starts nothing.
- R8: `last_rst_kind_o` changes only in the cycle in which `core_rst_o` falls, and it then takes the kind of the sequence that just ended.
- R9: A request that arrives while a sequence runs is ignored, with one exception. A system request that arrives during the assertion window of a core or chip sequence turns that sequence into a system reset and restarts its assertion window.
- R10: Pulling the shared line low itself does not start a second sequence once the first one ends.
- R11: After `rst`, no reset output is active, the line is not driven, all clock enables are 1 and `last_rst_kind_o` is 2'b00.
- R12: When several sources make a request in the same cycle, the strongest kind wins (system over chip over core).
- R13: The first `wdt_expire_i` pulse only arms the watchdog path. The next pulse requests a reset of kind `wdt_rst_kind_i`. A `wdt_ack_i` pulse disarms the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sys_rst_n_i | input | 1 | Sampled level of the shared open-drain reset line |
| sys_rst_drive_o | output | 1 | 1 pulls the shared reset line low |
| dbg_rst_kind_i | input | 2 | Reset request from the debug port (kind code) |
| wdt_expire_i | input | 1 | Watchdog expiry pulse |
| wdt_ack_i | input | 1 | Clears the armed watchdog state |
| wdt_rst_kind_i | input | 2 | Kind requested on a second watchdog expiry |
| sw_rst_wr_i | input | 1 | Strobe for the software reset field write |
| sw_rst_kind_i | input | 2 | Value written to the software reset field |
| pm_d0_wr_i | input | 1 | Power-state write requesting return to the full-power state |
| core_rst_o | output | 1 | Processor core reset, active high |
| chip_rst_o | output | 1 | On-chip peripheral reset, active high |
| ext_bus_rst_n_o | output | 1 | External bus reset, active low |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| pls_clk_en_o | output | 1 | PLS-domain clock enable |
| periph_clk_en_o | output | NUM_PCLK | Peripheral clock group enables |
| last_rst_kind_o | output | 2 | Kind of the last completed reset |

## Verification
The bench builds the block with FILT_CYC=4, ASSERT_CYC=16, LOCK_CYC=16, EARLY_CYC=4 and four clock groups. A full sequence then lasts about 32 cycles instead of more than 16000. This makes it cheap to sweep every request source against every reset kind and to count the exact length of each output window. The short filter puts both sides of the glitch threshold within a few cycles, and the short assertion window makes it easy to place upgrade and ignore requests in the assertion phase and in the lock phase.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'b00,
    RK_CORE = 2'b01,
    RK_CHIP = 2'b10,
    RK_SYS  = 2'b11
  } rst_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ASSERT,
    PH_EXTHOLD,
    PH_LOCK
  } seq_phase_e;

  // Stronger kind has the larger code.
  function automatic rst_kind_e kind_max(input rst_kind_e a, input rst_kind_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rsq_line_filter.sv
// Two-flop synchroniser and low-level glitch filter for the shared reset line.
module rsq_line_filter #(
  parameter int FILT_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic line_n_i,
  input  logic arm_i,        // count only while no sequence is running
  output logic hit_o,
  output logic line_high_o
);
  localparam int FW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
  localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

  logic          sync1_q, sync2_q;
  logic [FW-1:0] low_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= line_n_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt_q <= '0;
    end else if (!arm_i || sync2_q) begin
      low_cnt_q <= '0;
    end else if (low_cnt_q != LAST) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign hit_o       = arm_i && !sync2_q && (low_cnt_q == LAST);
  assign line_high_o = sync2_q;

endmodule

// File: rtl/rsq_req_merge.sv
// Collects processor-side and power-management requests into one kind.
module rsq_req_merge
  import rsq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      idle_i,
  input  rst_kind_e dbg_kind_i,
  input  logic      wdt_expire_i,
  input  logic      wdt_ack_i,
  input  rst_kind_e wdt_kind_i,
  input  logic      sw_wr_i,
  input  rst_kind_e sw_kind_i,
  input  logic      pm_d0_wr_i,
  output rst_kind_e req_kind_o
);
  logic      wdt_armed_q;
  logic      wdt_fire;
  rst_kind_e sw_req, wdt_req, pm_req;

  // First expiry arms, the next one fires; ack or any sequence disarms.
  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_armed_q <= 1'b0;
    end else if (wdt_ack_i || !idle_i) begin
      wdt_armed_q <= 1'b0;
    end else if (wdt_expire_i) begin
      wdt_armed_q <= 1'b1;
    end
  end

  assign wdt_fire = wdt_expire_i && wdt_armed_q;

  always_comb begin
    sw_req     = sw_wr_i    ? sw_kind_i  : RK_NONE;
    wdt_req    = wdt_fire   ? wdt_kind_i : RK_NONE;
    pm_req     = pm_d0_wr_i ? RK_SYS     : RK_NONE;
    req_kind_o = kind_max(kind_max(dbg_kind_i, sw_req), kind_max(wdt_req, pm_req));
  end

endmodule

// File: rtl/rsq_seq_core.sv
// Phase sequencer: assertion window, external hold, lock window, release.
module rsq_seq_core
  import rsq_pkg::*;
#(
  parameter int ASSERT_CYC = 8192,
  parameter int LOCK_CYC   = 8192,
  parameter int EARLY_CYC  = 64,
  parameter int NUM_PCLK   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  rst_kind_e           req_kind_i,
  input  logic                ext_hit_i,
  input  logic                line_high_i,
  output logic                idle_o,
  output logic                sys_drive_o,
  output logic                core_rst_o,
  output logic                chip_rst_o,
  output logic                ext_bus_rst_n_o,
  output logic [NUM_PCLK-1:0] pclk_en_o,
  output rst_kind_e           last_kind_o
);
  localparam int MAXC = (ASSERT_CYC > LOCK_CYC) ? ASSERT_CYC : LOCK_CYC;
  localparam int CW   = $clog2(MAXC);
  localparam logic [CW-1:0] ASSERT_LD = CW'(ASSERT_CYC - 1);
  localparam logic [CW-1:0] LOCK_LD   = CW'(LOCK_CYC - 1);
  localparam logic [CW-1:0] EARLY_LIM = CW'(EARLY_CYC);

  seq_phase_e    ph_q, ph_n;
  rst_kind_e     kind_q, kind_n, last_q, last_n;
  logic [CW-1:0] cnt_q, cnt_n;

  logic busy_n, early_n, drive_n, chip_n, pclk_n;
  logic drive_q, core_q, chip_q, extn_q;
  logic [NUM_PCLK-1:0] pclk_q;

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    kind_n = kind_q;
    last_n = last_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_kind_i != RK_NONE) begin
          ph_n   = PH_ASSERT;
          cnt_n  = ASSERT_LD;
          kind_n = req_kind_i;
        end else if (ext_hit_i) begin
          ph_n   = PH_EXTHOLD;
          cnt_n  = '0;
          kind_n = RK_SYS;
        end
      end
      PH_ASSERT: begin
        if (req_kind_i == RK_SYS && kind_q != RK_SYS) begin
          kind_n = RK_SYS;
          cnt_n  = ASSERT_LD;
        end else if (cnt_q == '0) begin
          ph_n  = PH_LOCK;
          cnt_n = LOCK_LD;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      PH_EXTHOLD: begin
        if (line_high_i) begin
          ph_n  = PH_LOCK;
          cnt_n = LOCK_LD;
        end
      end
      PH_LOCK: begin
        if (cnt_q == '0) begin
          ph_n   = PH_IDLE;
          last_n = kind_q;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  // Output values follow the next phase so they line up with the state.
  always_comb begin
    busy_n  = (ph_n != PH_IDLE);
    early_n = (ph_n == PH_LOCK) && (cnt_n < EARLY_LIM);
    drive_n = (ph_n == PH_ASSERT) && (kind_n == RK_SYS);
    chip_n  = busy_n && (kind_n != RK_CORE);
    pclk_n  = !busy_n || (kind_n != RK_SYS) || early_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      kind_q  <= RK_NONE;
      last_q  <= RK_NONE;
      drive_q <= 1'b0;
      core_q  <= 1'b0;
      chip_q  <= 1'b0;
      extn_q  <= 1'b1;
    end else begin
      ph_q    <= ph_n;
      cnt_q   <= cnt_n;
      kind_q  <= kind_n;
      last_q  <= last_n;
      drive_q <= drive_n;
      core_q  <= busy_n;
      chip_q  <= chip_n;
      extn_q  <= !chip_n;
    end
  end

  for (genvar g = 0; g < NUM_PCLK; g++) begin : g_pclk
    always_ff @(posedge clk) begin
      if (rst) pclk_q[g] <= 1'b1;
      else     pclk_q[g] <= pclk_n;
    end
  end

  assign idle_o          = (ph_q == PH_IDLE);
  assign sys_drive_o     = drive_q;
  assign core_rst_o      = core_q;
  assign chip_rst_o      = chip_q;
  assign ext_bus_rst_n_o = extn_q;
  assign pclk_en_o       = pclk_q;
  assign last_kind_o     = last_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsq_pkg::*;
#(
  parameter int FILT_CYC   = 16,
  parameter int ASSERT_CYC = 8192,
  parameter int LOCK_CYC   = 8192,
  parameter int EARLY_CYC  = 64,
  parameter int NUM_PCLK   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sys_rst_n_i,
  output logic                sys_rst_drive_o,
  input  logic [1:0]          dbg_rst_kind_i,
  input  logic                wdt_expire_i,
  input  logic                wdt_ack_i,
  input  logic [1:0]          wdt_rst_kind_i,
  input  logic                sw_rst_wr_i,
  input  logic [1:0]          sw_rst_kind_i,
  input  logic                pm_d0_wr_i,
  output logic                core_rst_o,
  output logic                chip_rst_o,
  output logic                ext_bus_rst_n_o,
  output logic                cpu_clk_en_o,
  output logic                pls_clk_en_o,
  output logic [NUM_PCLK-1:0] periph_clk_en_o,
  output logic [1:0]          last_rst_kind_o
);
  logic      idle, ext_hit, line_high;
  rst_kind_e req_kind, last_kind;

  rsq_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk         (clk),
    .rst         (rst),
    .line_n_i    (sys_rst_n_i),
    .arm_i       (idle),
    .hit_o       (ext_hit),
    .line_high_o (line_high)
  );

  rsq_req_merge u_req (
    .clk          (clk),
    .rst          (rst),
    .idle_i       (idle),
    .dbg_kind_i   (rst_kind_e'(dbg_rst_kind_i)),
    .wdt_expire_i (wdt_expire_i),
    .wdt_ack_i    (wdt_ack_i),
    .wdt_kind_i   (rst_kind_e'(wdt_rst_kind_i)),
    .sw_wr_i      (sw_rst_wr_i),
    .sw_kind_i    (rst_kind_e'(sw_rst_kind_i)),
    .pm_d0_wr_i   (pm_d0_wr_i),
    .req_kind_o   (req_kind)
  );

  rsq_seq_core #(
    .ASSERT_CYC (ASSERT_CYC),
    .LOCK_CYC   (LOCK_CYC),
    .EARLY_CYC  (EARLY_CYC),
    .NUM_PCLK   (NUM_PCLK)
  ) u_seq (
    .clk             (clk),
    .rst             (rst),
    .req_kind_i      (req_kind),
    .ext_hit_i       (ext_hit),
    .line_high_i     (line_high),
    .idle_o          (idle),
    .sys_drive_o     (sys_rst_drive_o),
    .core_rst_o      (core_rst_o),
    .chip_rst_o      (chip_rst_o),
    .ext_bus_rst_n_o (ext_bus_rst_n_o),
    .pclk_en_o       (periph_clk_en_o),
    .last_kind_o     (last_kind)
  );

  // Processor and PLS clocks keep running through every phase.
  assign cpu_clk_en_o    = 1'b1;
  assign pls_clk_en_o    = 1'b1;
  assign last_rst_kind_o = last_kind;

endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
  parameter int ASSERT_CYC = 8192,
  parameter int NUM_PCLK   = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                sys_rst_drive_o,
  input logic                core_rst_o,
  input logic                chip_rst_o,
  input logic                ext_bus_rst_n_o,
  input logic [NUM_PCLK-1:0] periph_clk_en_o,
  input logic [1:0]          last_rst_kind_o
);
  int unsigned drive_run_q;

  always_ff @(posedge clk) begin
    if (rst)                  drive_run_q <= 0;
    else if (sys_rst_drive_o) drive_run_q <= drive_run_q + 1;
    else                      drive_run_q <= 0;
  end

  // R2: the line is driven for exactly the assertion window
  assert_drive_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_drive_o) |-> (drive_run_q == ASSERT_CYC));

  // R2 / R5: driving happens only inside a full system reset
  assert_drive_sys_only_R2: assert property (@(posedge clk) disable iff (rst)
    sys_rst_drive_o |-> (core_rst_o && chip_rst_o && !ext_bus_rst_n_o));

  // R3: all resets leave together with clocks running
  assert_release_together_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o) |-> (!chip_rst_o && ext_bus_rst_n_o && (&periph_clk_en_o)));

  // R4: clock groups switch as one and are gated only under reset
  assert_pclk_group_R4: assert property (@(posedge clk) disable iff (rst)
    ($countones(periph_clk_en_o) == 0) || ($countones(periph_clk_en_o) == NUM_PCLK));

  assert_pclk_gated_in_rst_R4: assert property (@(posedge clk) disable iff (rst)
    !(&periph_clk_en_o) |-> core_rst_o);

  // R5: bus reset only inside a sequence
  assert_ext_bus_in_seq_R5: assert property (@(posedge clk) disable iff (rst)
    !ext_bus_rst_n_o |-> core_rst_o);

  // R8: status moves only at release
  assert_status_at_release_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(last_rst_kind_o) |-> $fell(core_rst_o));

endmodule

bind rst_seq_ctrl rsq_chk #(
  .ASSERT_CYC (ASSERT_CYC),
  .NUM_PCLK   (NUM_PCLK)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .sys_rst_drive_o (sys_rst_drive_o),
  .core_rst_o      (core_rst_o),
  .chip_rst_o      (chip_rst_o),
  .ext_bus_rst_n_o (ext_bus_rst_n_o),
  .periph_clk_en_o (periph_clk_en_o),
  .last_rst_kind_o (last_rst_kind_o)
);

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;
  localparam int FC = 4;
  localparam int AC = 16;
  localparam int LC = 16;
  localparam int EC = 4;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pull = 1'b0;
  logic sys_rst_n, drive;
  logic [1:0] dbg_kind = 2'b00, wdt_kind = 2'b00, sw_kind = 2'b00;
  logic wdt_exp = 1'b0, wdt_ack = 1'b0, sw_wr = 1'b0, pm_wr = 1'b0;
  logic core_rst, chip_rst, ext_bus_n, cpu_en, pls_en;
  logic [NP-1:0] pclk_en;
  logic [1:0] last_kind;

  int n_chk = 0;
  int n_err = 0;
  bit timed_out = 1'b0;

  always #2 clk = ~clk;

  // Open-drain line: low if the block or an outside device pulls it.
  assign sys_rst_n = !(drive | ext_pull);

  rst_seq_ctrl #(
    .FILT_CYC (FC), .ASSERT_CYC (AC), .LOCK_CYC (LC), .EARLY_CYC (EC), .NUM_PCLK (NP)
  ) dut (
    .clk (clk), .rst (rst), .sys_rst_n_i (sys_rst_n), .sys_rst_drive_o (drive),
    .dbg_rst_kind_i (dbg_kind), .wdt_expire_i (wdt_exp), .wdt_ack_i (wdt_ack),
    .wdt_rst_kind_i (wdt_kind), .sw_rst_wr_i (sw_wr), .sw_rst_kind_i (sw_kind),
    .pm_d0_wr_i (pm_wr), .core_rst_o (core_rst), .chip_rst_o (chip_rst),
    .ext_bus_rst_n_o (ext_bus_n), .cpu_clk_en_o (cpu_en), .pls_clk_en_o (pls_en),
    .periph_clk_en_o (pclk_en), .last_rst_kind_o (last_kind)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    dbg_kind = 2'b00; sw_wr = 1'b0; sw_kind = 2'b00;
    wdt_exp = 1'b0; wdt_ack = 1'b0; pm_wr = 1'b0;
  endtask

  // Returns the number of the next n cycles in which core_rst was high.
  task automatic quiet_cycles(input int n, output int busy);
    busy = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clear_in();
      busy += int'(core_rst);
    end
  endtask

  // src: 0 debug, 1 software, 2 watchdog (armed beforehand), 3 power management
  task automatic run_seq(input int src, input logic [1:0] kind, input logic [1:0] sw_extra,
                         input int inj_at, input logic [1:0] inj_kind,
                         output int n_core, output int n_drive, output int n_chip,
                         output int n_ext, output int n_plow, output int n_cpuoff,
                         output int mid_last);
    n_core = 0; n_drive = 0; n_chip = 0; n_ext = 0; n_plow = 0; n_cpuoff = 0; mid_last = -1;
    @(negedge clk);
    case (src)
      0: dbg_kind = kind;
      1: begin sw_wr = 1'b1; sw_kind = kind; end
      2: begin wdt_kind = kind; wdt_exp = 1'b1; end
      default: pm_wr = 1'b1;
    endcase
    if (sw_extra != 2'b00) begin sw_wr = 1'b1; sw_kind = sw_extra; end
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      clear_in();
      if (inj_at > 0 && i == inj_at - 1) dbg_kind = inj_kind;
      if (i == 0) mid_last = int'(last_kind);
      if (!core_rst) break;
      n_core   += 1;
      n_drive  += int'(drive);
      n_chip   += int'(chip_rst);
      n_ext    += int'(!ext_bus_n);
      n_plow   += int'(pclk_en != '1);
      n_cpuoff += int'(!(cpu_en && pls_en));
    end
  endtask

  task automatic run_all();
    int nc, nd, nch, ne, np, nco, ml, busy, prev;
    int ext_core, ext_drive, ext_plow;
    bit seen;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11 core_rst", int'(core_rst), 0);
    chk("R11 chip_rst", int'(chip_rst), 0);
    chk("R11 ext_bus_rst_n", int'(ext_bus_n), 1);
    chk("R11 drive", int'(drive), 0);
    chk("R11 periph_en", int'(pclk_en), (1 << NP) - 1);
    chk("R11 cpu/pls_en", int'(cpu_en && pls_en), 1);
    chk("R11 last_kind", int'(last_kind), 0);
    prev = 0;

    // R7 / R2 / R3 / R4 / R5 / R8 / R10 / R13: every source against every kind
    for (int src = 0; src < 3; src++) begin
      for (int k = 1; k < 4; k++) begin
        if (src == 2) begin
          // R13: arm, ack, re-arm; none of these starts a reset
          @(negedge clk); wdt_exp = 1'b1;
          @(negedge clk); clear_in(); wdt_ack = 1'b1;
          @(negedge clk); clear_in(); wdt_exp = 1'b1;
          quiet_cycles(4, busy);
          chk("R13 first expiry after ack no reset", busy, 0);
        end
        run_seq(src, 2'(k), 2'b00, 0, 2'b00, nc, nd, nch, ne, np, nco, ml);
        chk("R3 core_rst length", nc, AC + LC);
        chk("R2 drive length", nd, (k == 3) ? AC : 0);
        chk("R5 chip_rst length", nch, (k != 1) ? AC + LC : 0);
        chk("R5 ext bus low length", ne, (k != 1) ? AC + LC : 0);
        chk("R4 periph gated length", np, (k == 3) ? AC + LC - EC : 0);
        chk("R4 cpu/pls never off", nco, 0);
        chk("R8 status held mid-sequence", ml, prev);
        chk("R7 last kind", int'(last_kind), k);
        prev = k;
        quiet_cycles(6, busy);
        chk("R10 no second sequence", busy, 0);
      end
    end

    // R6: power-state write gives a system reset
    run_seq(3, 2'b00, 2'b00, 0, 2'b00, nc, nd, nch, ne, np, nco, ml);
    chk("R6 drive length", nd, AC);
    chk("R6 last kind", int'(last_kind), 3);
    quiet_cycles(4, busy);

    // R7: software write of 00 does nothing
    @(negedge clk); sw_wr = 1'b1; sw_kind = 2'b00;
    quiet_cycles(6, busy);
    chk("R7 write 00 ignored", busy, 0);
    chk("R7 status kept", int'(last_kind), 3);

    // R12: core from debug and chip from software together -> chip
    run_seq(0, 2'b01, 2'b10, 0, 2'b00, nc, nd, nch, ne, np, nco, ml);
    chk("R12 chip_rst length", nch, AC + LC);
    chk("R12 last kind", int'(last_kind), 2);
    quiet_cycles(3, busy);

    // R9: system request during core assertion window upgrades and restarts
    run_seq(0, 2'b01, 2'b00, 3, 2'b11, nc, nd, nch, ne, np, nco, ml);
    chk("R9 upgrade core_rst length", nc, 3 + AC + LC);
    chk("R9 upgrade drive length", nd, AC);
    chk("R9 upgrade chip_rst length", nch, AC + LC);
    chk("R9 upgrade periph gated", np, AC + LC - EC);
    chk("R9 upgrade last kind", int'(last_kind), 3);
    quiet_cycles(4, busy);

    // R9: system request in the lock window is ignored
    run_seq(0, 2'b10, 2'b00, AC + 2, 2'b11, nc, nd, nch, ne, np, nco, ml);
    chk("R9 lock-phase request core_rst", nc, AC + LC);
    chk("R9 lock-phase request drive", nd, 0);
    chk("R9 lock-phase request last kind", int'(last_kind), 2);
    quiet_cycles(4, busy);

    // R9: chip request during core assertion is ignored
    run_seq(0, 2'b01, 2'b00, 2, 2'b10, nc, nd, nch, ne, np, nco, ml);
    chk("R9 non-system upgrade ignored chip_rst", nch, 0);
    chk("R9 non-system upgrade last kind", int'(last_kind), 1);
    quiet_cycles(4, busy);

    // R1: glitch shorter than the filter
    for (int len = 1; len < FC; len++) begin
      @(negedge clk); ext_pull = 1'b1;
      repeat (len) @(negedge clk);
      ext_pull = 1'b0;
      quiet_cycles(8, busy);
      chk("R1 short low ignored", busy, 0);
    end

    // R1: exactly FC low samples is recognised
    @(negedge clk); ext_pull = 1'b1;
    repeat (FC) @(negedge clk);
    ext_pull = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (core_rst) seen = 1'b1;
      if (seen && !core_rst) break;
    end
    chk("R1 boundary low recognised", int'(seen), 1);
    chk("R1 boundary last kind", int'(last_kind), 3);
    quiet_cycles(4, busy);

    // R1 / R4: long external hold, measured from release of the line
    @(negedge clk); ext_pull = 1'b1;
    repeat (FC + 6) @(negedge clk);
    chk("R1 held line in reset", int'(core_rst), 1);
    chk("R1 no self drive while held", int'(drive), 0);
    ext_pull = 1'b0;
    ext_core = 0; ext_drive = 0; ext_plow = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!core_rst) break;
      ext_core  += 1;
      ext_drive += int'(drive);
      ext_plow  += int'(pclk_en != '1);
    end
    chk("R1 lock after line high", ext_core, LC + 2);
    chk("R1 external no drive", ext_drive, 0);
    chk("R4 external periph gated", ext_plow, LC + 2 - EC);
    chk("R3 external release together", int'(chip_rst) + int'(!ext_bus_n), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule